// File: doc/BRIEF.md
# Fast Link Pulse Burst Transmitter

This block turns one 16-bit auto-negotiation page into a burst of link pulses on a single-bit output. A burst holds 33 pulse positions at a fixed spacing. Positions that carry timing always get a pulse. The positions between them each carry one page bit: a pulse for a one and no pulse for a zero. The spacing and the width of each pulse are counted in system-clock cycles and set by parameters. The defaults give 62.5 µs slots and pulses of about 100 ns at 100 MHz, and a simulation can shrink both.

A negotiation controller presents a page and raises `start` while the block is idle. The page and the interburst interval are captured on that edge. The block then drives `busy` and emits the burst, and it raises `done` for one cycle after the last position has elapsed. If `repeat_en` is high when a burst ends, the block sends the same captured page again. The next burst begins a programmed number of cycles after the start of the previous one, measured start to start, which is nominally 16 ms. Lowering `repeat_en` stops the repetition.

Top module: `flp_burst_tx`

## Requirements
- R1: After reset `pulse_out`, `busy` and `done` are all low.
- R2: A burst spans 33 positions of SLOT_CYCLES cycles each. Position p (0-based) begins p*SLOT_CYCLES cycles after the first burst cycle, and the first burst cycle is the cycle right after the clock edge that accepts `start`.
- R3: Every position with an even 0-based index (0, 2, ..., 32) carries a pulse, whatever the page holds.
- R4: Position 2i+1 (0-based) carries page bit i, least significant bit first, so bit 0 sits in position 1 and bit 15 in position 31. A 1 gives a pulse and a 0 gives no pulse, so a burst contains 17 plus the page's count of ones pulses.
- R5: Each pulse is high for exactly PULSE_CYCLES consecutive cycles, starting in the first cycle of its position. The output is low for the rest of that position.
- R6: `start` is accepted only while `busy` is low, and the page and gap are captured only on that edge. While busy, `start`, `page_in` and `gap_cycles` have no effect on the output.
- R7: `busy` is high from the first burst cycle to the last. `done` is high for exactly one cycle, the cycle right after the last burst cycle. In that cycle `busy` is low unless a repeat is pending.
- R8: If `repeat_en` is high at the end of a burst, the block sends the captured page again. The next burst starts max(gap, 33*SLOT_CYCLES+1) cycles after the first cycle of the previous burst.
- R9: If `repeat_en` is low when a burst ends, or drops during the gap, the block goes idle (`busy` low) and emits no further pulses.
- R10: `pulse_out` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Request a burst; accepted only while idle |
| page_in | input | PAGE_W | Page to send, captured with `start` |
| repeat_en | input | 1 | Keep repeating the burst while high |
| gap_cycles | input | GAP_W | Start-to-start interval between repeated bursts, in cycles, captured with `start` |
| pulse_out | output | 1 | Link pulse output |
| busy | output | 1 | A burst or an interburst gap is in progress |
| done | output | 1 | One-cycle strobe after the last position of each burst |

## Verification
The checker enforces several rules on every cycle. It confines pulses to busy periods and checks that every pulse lasts exactly PULSE_CYCLES. It also checks that `done` is a single-cycle strobe that follows a busy cycle. The bench scenarios cover what needs a reference model: which positions carry pulses for a given page, bit order, slot placement, rejection of new requests during a burst, and start-to-start spacing for long and short gaps. They also cover how the block stops when `repeat_en` falls during a burst or during a gap.

// File: rtl/flp_pkg.sv
package flp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BURST = 2'd1,
    ST_GAP   = 2'd2
  } flp_state_e;
endpackage

// File: rtl/flp_slot_timer.sv
module flp_slot_timer #(
  parameter int SLOT_CYCLES = 6250,
  parameter int POSITIONS   = 33,
  parameter int CNT_W       = $clog2(SLOT_CYCLES),
  parameter int POS_W       = $clog2(POSITIONS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [CNT_W-1:0] slot_cnt,
  output logic [POS_W-1:0] pos_idx,
  output logic             burst_end
);
  localparam logic [CNT_W-1:0] SLOT_LAST = CNT_W'(SLOT_CYCLES - 1);
  localparam logic [POS_W-1:0] POS_LAST  = POS_W'(POSITIONS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic             slot_end;

  assign slot_end = (cnt_q == SLOT_LAST);

  always_comb begin
    cnt_d = cnt_q;
    pos_d = pos_q;
    if (!en) begin
      cnt_d = '0;
      pos_d = '0;
    end else if (slot_end) begin
      cnt_d = '0;
      pos_d = pos_q + 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pos_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      pos_q <= pos_d;
    end
  end

  assign slot_cnt  = cnt_q;
  assign pos_idx   = pos_q;
  assign burst_end = en && slot_end && (pos_q == POS_LAST);
endmodule

// File: rtl/flp_pulse_shaper.sv
module flp_pulse_shaper #(
  parameter int PAGE_W       = 16,
  parameter int PULSE_CYCLES = 10,
  parameter int POSITIONS    = 2 * PAGE_W + 1,
  parameter int CNT_W        = 13,
  parameter int POS_W        = $clog2(POSITIONS)
) (
  input  logic              en,
  input  logic [PAGE_W-1:0] page,
  input  logic [CNT_W-1:0]  slot_cnt,
  input  logic [POS_W-1:0]  pos_idx,
  output logic              pulse
);
  localparam logic [CNT_W-1:0] WIDTH_LIM = CNT_W'(PULSE_CYCLES);

  logic [POSITIONS-1:0] pos_map;
  logic                 in_window;

  for (genvar p = 0; p < POSITIONS; p++) begin : g_map
    if ((p % 2) == 0) begin : g_clk
      assign pos_map[p] = 1'b1;
    end else begin : g_dat
      assign pos_map[p] = page[p / 2];
    end
  end

  assign in_window = (slot_cnt < WIDTH_LIM);
  assign pulse     = en && in_window && pos_map[pos_idx];
endmodule

// File: rtl/flp_burst_ctrl.sv
module flp_burst_ctrl
  import flp_pkg::*;
#(
  parameter int PAGE_W = 16,
  parameter int GAP_W  = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAGE_W-1:0] page_in,
  input  logic              repeat_en,
  input  logic [GAP_W-1:0]  gap_in,
  input  logic              burst_end,
  output logic [PAGE_W-1:0] page,
  output logic              burst_en,
  output logic              busy,
  output logic              done
);
  flp_state_e        state_q, state_d;
  logic [PAGE_W-1:0] page_q;
  logic [GAP_W-1:0]  gap_q;
  logic [GAP_W-1:0]  epoch_q, epoch_d;
  logic              done_q, done_d;
  logic              cap_en;
  logic [GAP_W:0]    epoch_nx;
  logic [GAP_W-1:0]  epoch_inc;
  logic              gap_reached;

  assign cap_en      = (state_q == ST_IDLE) && start;
  assign epoch_nx    = {1'b0, epoch_q} + {{GAP_W{1'b0}}, 1'b1};
  assign epoch_inc   = epoch_nx[GAP_W] ? epoch_q : epoch_nx[GAP_W-1:0];
  assign gap_reached = (epoch_nx >= {1'b0, gap_q});

  always_comb begin
    state_d = state_q;
    epoch_d = epoch_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_BURST;
          epoch_d = '0;
        end
      end
      ST_BURST: begin
        epoch_d = epoch_inc;
        if (burst_end) state_d = repeat_en ? ST_GAP : ST_IDLE;
      end
      ST_GAP: begin
        if (!repeat_en) begin
          state_d = ST_IDLE;
        end else if (gap_reached) begin
          state_d = ST_BURST;
          epoch_d = '0;
        end else begin
          epoch_d = epoch_inc;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    done_d = (state_q == ST_BURST) && burst_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      epoch_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      epoch_q <= epoch_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      gap_q  <= '0;
    end else if (cap_en) begin
      page_q <= page_in;
      gap_q  <= gap_in;
    end
  end

  assign page     = page_q;
  assign burst_en = (state_q == ST_BURST);
  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
endmodule

// File: rtl/flp_burst_tx.sv
module flp_burst_tx #(
  parameter int PAGE_W       = 16,
  parameter int SLOT_CYCLES  = 6250,
  parameter int PULSE_CYCLES = 10,
  parameter int GAP_W        = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAGE_W-1:0] page_in,
  input  logic              repeat_en,
  input  logic [GAP_W-1:0]  gap_cycles,
  output logic              pulse_out,
  output logic              busy,
  output logic              done
);
  localparam int POSITIONS = 2 * PAGE_W + 1;
  localparam int CNT_W     = $clog2(SLOT_CYCLES);
  localparam int POS_W     = $clog2(POSITIONS);

  logic [1:0]        rst_sync;
  logic              rst_n_s;
  logic [PAGE_W-1:0] page;
  logic              burst_en;
  logic              burst_end;
  logic [CNT_W-1:0]  slot_cnt;
  logic [POS_W-1:0]  pos_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  flp_burst_ctrl #(
    .PAGE_W(PAGE_W),
    .GAP_W (GAP_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .start    (start),
    .page_in  (page_in),
    .repeat_en(repeat_en),
    .gap_in   (gap_cycles),
    .burst_end(burst_end),
    .page     (page),
    .burst_en (burst_en),
    .busy     (busy),
    .done     (done)
  );

  flp_slot_timer #(
    .SLOT_CYCLES(SLOT_CYCLES),
    .POSITIONS  (POSITIONS),
    .CNT_W      (CNT_W),
    .POS_W      (POS_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .en       (burst_en),
    .slot_cnt (slot_cnt),
    .pos_idx  (pos_idx),
    .burst_end(burst_end)
  );

  flp_pulse_shaper #(
    .PAGE_W      (PAGE_W),
    .PULSE_CYCLES(PULSE_CYCLES),
    .POSITIONS   (POSITIONS),
    .CNT_W       (CNT_W),
    .POS_W       (POS_W)
  ) u_shaper (
    .en      (burst_en),
    .page    (page),
    .slot_cnt(slot_cnt),
    .pos_idx (pos_idx),
    .pulse   (pulse_out)
  );
endmodule

// File: rtl/flp_burst_tx_chk.sv
module flp_burst_tx_chk #(
  parameter int PULSE_CYCLES = 10
) (
  input logic clk,
  input logic rst_n,
  input logic pulse_out,
  input logic busy,
  input logic done
);
  localparam int RUN_W = $clog2(PULSE_CYCLES + 2);
  localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

  logic [RUN_W-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            run_len <= '0;
    else if (!pulse_out)                   run_len <= '0;
    else if (run_len != RUN_MAX)           run_len <= run_len + 1'b1;
  end

  // R10
  pulse_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_out |-> busy);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  // R5
  pulse_len_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_out |-> (run_len < RUN_W'(PULSE_CYCLES)));

  // R5
  pulse_len_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_out) |-> (run_len == RUN_W'(PULSE_CYCLES)));
endmodule

bind flp_burst_tx flp_burst_tx_chk #(
  .PULSE_CYCLES(PULSE_CYCLES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pulse_out(pulse_out),
  .busy     (busy),
  .done     (done)
);

// File: tb/sim_flp_burst_tx.sv
module sim_flp_burst_tx;
  localparam int CLK_PERIOD = 10;
  localparam int PAGE_W     = 16;
  localparam int SLOT       = 20;
  localparam int PULSE      = 3;
  localparam int GAP_W      = 12;
  localparam int BURST_LEN  = 33 * SLOT;
  localparam int NVEC       = 5;
  // each entry: {page, expected pulse count per burst}
  localparam logic [PAGE_W+5:0] VECS [NVEC] = '{
    {16'h0000, 6'd17},
    {16'hFFFF, 6'd33},
    {16'hA5C3, 6'd25},
    {16'h0001, 6'd18},
    {16'h8000, 6'd18}
  };

  logic              clk;
  logic              rst_n;
  logic              start;
  logic [PAGE_W-1:0] page_in;
  logic              repeat_en;
  logic [GAP_W-1:0]  gap_cycles;
  logic              pulse_out;
  logic              busy;
  logic              done;

  int total;
  int bad;
  int cycles;
  bit finished;

  flp_burst_tx #(
    .PAGE_W      (PAGE_W),
    .SLOT_CYCLES (SLOT),
    .PULSE_CYCLES(PULSE),
    .GAP_W       (GAP_W)
  ) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .page_in   (page_in),
    .repeat_en (repeat_en),
    .gap_cycles(gap_cycles),
    .pulse_out (pulse_out),
    .busy      (busy),
    .done      (done)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !finished) begin
        bad++;
        total++;
        $display("FAIL watchdog: act=%0d cycles exp<150000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_pulse(input logic [PAGE_W-1:0] pg, input int k);
    int p;
    int c;
    p = k / SLOT;
    c = k % SLOT;
    if (c >= PULSE) return 1'b0;
    if ((p % 2) == 0) return 1'b1;
    return pg[p / 2];
  endfunction

  // Entered at the sampling point of burst cycle 0, leaves at the done cycle.
  task automatic run_burst(input logic [PAGE_W-1:0] pg, input bit poke, input int drop_at,
                           output int mism, output int npulse, output int nbusy_low);
    mism = 0;
    npulse = 0;
    nbusy_low = 0;
    for (int k = 0; k < BURST_LEN; k++) begin
      if (pulse_out !== exp_pulse(pg, k)) mism++;
      if (pulse_out && (k % SLOT) == 0) npulse++;
      if (busy !== 1'b1) nbusy_low++;
      start = 1'b0;
      if (poke && k == 5 * SLOT) begin
        start = 1'b1;
        page_in = ~pg;
        gap_cycles = 12'd7;
      end
      if (k == drop_at) repeat_en = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic kick(input logic [PAGE_W-1:0] pg, input logic [GAP_W-1:0] gp);
    page_in = pg;
    gap_cycles = gp;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    int mism;
    int np;
    int bl;
    int hits;
    total = 0;
    bad = 0;
    finished = 0;
    rst_n = 1'b0;
    start = 1'b0;
    page_in = '0;
    repeat_en = 1'b0;
    gap_cycles = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(pulse_out === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 reset outputs",
          {pulse_out, busy, done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(pulse_out === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 after release",
          {pulse_out, busy, done}, 0);

    // Table walk: R2 R3 R4 R5 pattern, R6 mid-burst start ignored, R7 done, R9/R10 idle
    for (int v = 0; v < NVEC; v++) begin
      logic [PAGE_W-1:0] pg;
      int expn;
      pg = VECS[v][PAGE_W+5:6];
      expn = int'(VECS[v][5:0]);
      kick(pg, 12'd0);
      run_burst(pg, 1'b1, -1, mism, np, bl);
      check(mism == 0, "R2/R3/R4/R5/R6 pulse pattern", mism, 0);
      check(np == expn, "R4 pulse count", np, expn);
      check(bl == 0, "R7 busy during burst", bl, 0);
      check(done === 1'b1 && busy === 1'b0, "R7 done strobe, idle", {done, busy}, 2);
      hits = 0;
      for (int k = 0; k < 3 * SLOT; k++) begin
        @(negedge clk);
        if (pulse_out !== 1'b0 || busy !== 1'b0 || done !== 1'b0) hits++;
      end
      check(hits == 0, "R9/R10 quiet after burst", hits, 0);
    end

    // R8: repeat with long gap, R9: drop during second burst
    repeat_en = 1'b1;
    kick(16'h1234, 12'd1000);
    run_burst(16'h1234, 1'b0, -1, mism, np, bl);
    check(mism == 0, "R8 first repeat burst", mism, 0);
    check(done === 1'b1 && busy === 1'b1, "R7 done with repeat pending", {done, busy}, 3);
    hits = 0;
    for (int e = BURST_LEN; e < 1000; e++) begin
      if (pulse_out !== 1'b0 || busy !== 1'b1) hits++;
      @(negedge clk);
    end
    check(hits == 0, "R8 silent gap", hits, 0);
    run_burst(16'h1234, 1'b0, 10, mism, np, bl);
    check(mism == 0, "R8 second burst at start-to-start gap", mism, 0);
    check(done === 1'b1 && busy === 1'b0, "R9 stop after drop in burst", {done, busy}, 2);

    // R8: gap shorter than burst -> restart right after done cycle
    repeat (5) @(negedge clk);
    repeat_en = 1'b1;
    kick(16'h00F0, 12'd5);
    run_burst(16'h00F0, 1'b0, -1, mism, np, bl);
    check(done === 1'b1 && busy === 1'b1, "R8 short gap done", {done, busy}, 3);
    @(negedge clk);
    run_burst(16'h00F0, 1'b0, 0, mism, np, bl);
    check(mism == 0, "R8 back-to-back burst", mism, 0);
    check(busy === 1'b0, "R9 idle after short-gap stop", busy, 0);

    // R9: drop repeat during the gap
    repeat (5) @(negedge clk);
    repeat_en = 1'b1;
    kick(16'hFFFF, 12'd1500);
    run_burst(16'hFFFF, 1'b0, -1, mism, np, bl);
    repeat (10) @(negedge clk);
    repeat_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    hits = 0;
    for (int k = 0; k < 1000; k++) begin
      if (pulse_out !== 1'b0 || busy !== 1'b0) hits++;
      @(negedge clk);
    end
    check(hits == 0, "R9 drop during gap", hits, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule